// File: doc/BRIEF.md
# Prioritised UART Interrupt Status Unit

This block decides which interrupt a UART presents to its host. Six event conditions are watched every clock: a receive line error, receive data at or above a selectable fill level, a receive timeout, transmit FIFO fill below a selectable level, a modem status change and one auxiliary source. A condition only counts when its enable bit is set. A counted condition is latched as pending.

One pending source at a time is reported on a one-hot status code, and the interrupt line is raised while a code is shown. Once a source is shown, the code is frozen until the host services it with a status read strobe. A read clears only the source being shown. The next pending source, chosen by fixed priority, is shown from the following clock. The two fill thresholds come from small fixed tables indexed by 2-bit selects.

Top module: `uart_irq_prio`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `stat_o` is 6'b000000 and `irq_o` is 0.
- R2: `stat_o` is one-hot or zero. Bit 0 is the line error, bit 1 is receive data, bit 2 is receive timeout, bit 3 is transmit, bit 4 is modem and bit 5 is auxiliary. When several sources are pending while nothing is shown, the lowest bit index wins.
- R3: A clock edge with `stat_rd` high clears only the source being shown. From that edge on, the highest remaining pending source is shown, or zero if none remains.
- R4: While a code is shown, it stays unchanged until a read occurs, even if a higher-priority source becomes pending.
- R5: The transmit condition is `tx_count` < level. `tx_lvl_sel` values 0, 1, 2 and 3 select the levels 8, 16, 32 and 56.
- R6: The receive data condition is `rx_count` >= level. `rx_lvl_sel` values 0, 1, 2 and 3 select the levels 8, 16, 56 and 60.
- R7: A source whose `src_en` bit is 0 never becomes pending. Clearing the bit drops that source if it is pending.
- R8: If a source's condition is still true when it is cleared by a read, it is latched again on the next clock edge.
- R9: `irq_o` is 1 exactly when `stat_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line_err | input | 1 | Receive line error condition |
| ev_rx_tmo | input | 1 | Receive timeout condition |
| ev_modem | input | 1 | Modem status change condition |
| ev_aux | input | 1 | Auxiliary source condition |
| src_en | input | 6 | Per-source enables, same bit order as `stat_o` |
| tx_lvl_sel | input | 2 | Transmit threshold select |
| rx_lvl_sel | input | 2 | Receive threshold select |
| tx_count | input | CNT_W | Transmit FIFO fill |
| rx_count | input | CNT_W | Receive FIFO fill |
| stat_rd | input | 1 | Status read strobe, one clock per read |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 6 | One-hot code of the shown source |

## Verification
The hardest case to reach is a higher-priority source that arrives while a lower one is already shown. The stimulus first raises only the auxiliary source, lets it be shown, and then raises the line error and modem sources. This checks that the code stays frozen, and that successive reads then uncover the queued sources in priority order. A second hard case is a condition that is still true when it is cleared. The stimulus keeps the line error high across a read and expects one clock of zero before the source is latched again.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_line_err,
  input  logic             ev_rx_tmo,
  input  logic             ev_modem,
  input  logic             ev_aux,
  input  logic [5:0]       src_en,
  input  logic [1:0]       tx_lvl_sel,
  input  logic [1:0]       rx_lvl_sel,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             stat_rd,
  output logic             irq_o,
  output logic [5:0]       stat_o
);

  logic [CNT_W-1:0] tx_lvl, rx_lvl;
  logic [5:0] cond, pend, pend_n, cur, cur_n, clr;

  always_comb begin
    case (tx_lvl_sel)
      2'd0:    tx_lvl = CNT_W'(8);
      2'd1:    tx_lvl = CNT_W'(16);
      2'd2:    tx_lvl = CNT_W'(32);
      default: tx_lvl = CNT_W'(56);
    endcase
    case (rx_lvl_sel)
      2'd0:    rx_lvl = CNT_W'(8);
      2'd1:    rx_lvl = CNT_W'(16);
      2'd2:    rx_lvl = CNT_W'(56);
      default: rx_lvl = CNT_W'(60);
    endcase
  end

  assign cond = {ev_aux, ev_modem, tx_count < tx_lvl, ev_rx_tmo,
                 rx_count >= rx_lvl, ev_line_err};

  assign clr    = stat_rd ? cur : 6'd0;
  assign pend_n = ((pend | cond) & ~clr) & src_en;
  assign cur_n  = |(cur & pend_n) ? cur : (pend_n & (~pend_n + 6'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      cur  <= '0;
    end else begin
      pend <= pend_n;
      cur  <= cur_n;
    end
  end

  assign stat_o = cur;
  assign irq_o  = |cur;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_o));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 6'd0) |-> (stat_o == 6'd0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != 6'd0 && !stat_rd && (stat_o & src_en) == stat_o) |=> $stable(stat_o));

  assert_read_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && stat_o != 6'd0) |=> (stat_o != $past(stat_o)));

  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & ~$past(src_en)) == 6'd0));

endmodule

// File: tb/tb_uart_irq_prio.sv
module tb_uart_irq_prio;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 7;

  logic clk = 0, rst_n = 0;
  logic ev_line_err = 0, ev_rx_tmo = 0, ev_modem = 0, ev_aux = 0;
  logic [5:0] src_en = '0;
  logic [1:0] tx_lvl_sel = 0, rx_lvl_sel = 0;
  logic [CNT_W-1:0] tx_count = 7'd64, rx_count = 0;
  logic stat_rd = 0;
  logic irq_o;
  logic [5:0] stat_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [5:0] st; string req; } exp_t;
  exp_t q[$];

  uart_irq_prio #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ev_line_err(ev_line_err), .ev_rx_tmo(ev_rx_tmo),
    .ev_modem(ev_modem), .ev_aux(ev_aux), .src_en(src_en),
    .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel), .tx_count(tx_count),
    .rx_count(rx_count), .stat_rd(stat_rd), .irq_o(irq_o), .stat_o(stat_o));

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (stat_o !== e.st) begin
        bad++;
        $display("FAIL %s: stat actual=%b expected=%b", e.req, stat_o, e.st);
      end
      total++;
      if (irq_o !== (e.st != 6'd0)) begin
        bad++;
        $display("FAIL R9 (%s): irq actual=%b expected=%b", e.req, irq_o, e.st != 6'd0);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    stat_rd = 0;
  endtask

  task automatic expect_st(input logic [5:0] st, input string req);
    exp_t e;
    e.st = st; e.req = req;
    q.push_back(e);
  endtask

  task automatic read_step();
    stat_rd = 1;
    step();
  endtask

  initial begin
    int tx_tab[4] = '{8, 16, 32, 56};
    int rx_tab[4] = '{8, 16, 56, 60};
    step();
    expect_st(6'd0, "R1");
    step();
    rst_n = 1;
    step();
    expect_st(6'd0, "R1");

    // R4: queued sources behind a shown one
    src_en = 6'h3F;
    ev_aux = 1; step(); expect_st(6'b100000, "R2");
    ev_modem = 1; ev_line_err = 1; step(); expect_st(6'b100000, "R4");
    step(); expect_st(6'b100000, "R4");
    ev_aux = 0; read_step(); expect_st(6'b000001, "R3");
    ev_line_err = 0; read_step(); expect_st(6'b010000, "R3");
    ev_modem = 0; read_step(); expect_st(6'b000000, "R3");

    // R8: relatch of a condition still true
    ev_line_err = 1; step(); expect_st(6'b000001, "R8");
    read_step(); expect_st(6'b000000, "R8");
    step(); expect_st(6'b000001, "R8");
    ev_line_err = 0; read_step(); expect_st(6'b000000, "R8");

    // R5: transmit thresholds
    for (int s = 0; s < 4; s++) begin
      tx_lvl_sel = 2'(s);
      tx_count = 7'(tx_tab[s]); step(); expect_st(6'b000000, "R5");
      tx_count = 7'(tx_tab[s] - 1); step(); expect_st(6'b001000, "R5");
      tx_count = 7'd64; read_step(); expect_st(6'b000000, "R5");
      step(); expect_st(6'b000000, "R5");
    end

    // R6: receive thresholds
    for (int s = 0; s < 4; s++) begin
      rx_lvl_sel = 2'(s);
      rx_count = 7'(rx_tab[s] - 1); step(); expect_st(6'b000000, "R6");
      rx_count = 7'(rx_tab[s]); step(); expect_st(6'b000010, "R6");
      rx_count = 7'd0; read_step(); expect_st(6'b000000, "R6");
      step(); expect_st(6'b000000, "R6");
    end
    tx_lvl_sel = 0; rx_lvl_sel = 0;

    // R7: enables
    src_en[2] = 0; ev_rx_tmo = 1; step(); expect_st(6'b000000, "R7");
    step(); expect_st(6'b000000, "R7");
    src_en[2] = 1; step(); expect_st(6'b000100, "R7");
    src_en[2] = 0; step(); expect_st(6'b000000, "R7");
    ev_rx_tmo = 0; src_en = 6'h3F; step(); expect_st(6'b000000, "R7");

    // R2: simultaneous arrival, priority order
    ev_line_err = 1; ev_rx_tmo = 1; tx_count = 0; ev_modem = 1;
    step(); expect_st(6'b000001, "R2");
    ev_line_err = 0; read_step(); expect_st(6'b000100, "R2");
    ev_rx_tmo = 0; read_step(); expect_st(6'b001000, "R2");
    tx_count = 7'd64; read_step(); expect_st(6'b010000, "R2");
    ev_modem = 0; read_step(); expect_st(6'b000000, "R3");

    step(); step();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule